// File: doc/BRIEF.md
# Configuration Port Decoder

This block sits behind an 8-byte I/O port window and provides indirect access to a configuration space. Byte offsets 0 to 3 of the window hold a 32-bit address register that selects the target: an enable bit, a bus number, a device number, a function number and a dword-aligned register offset. Byte offsets 4 to 7 form a data window. A host access there is turned into one request to a downstream configuration responder. That request targets the register named by the address register.

The host may access either half with 1-, 2- or 4-byte operations. Partial writes to the address register change only the bytes they cover. Partial reads return the addressed bytes right-aligned. In the data window, the byte position inside the window is placed in the low two bits of the effective register offset. For example, a 16-bit read at window byte 2 reaches the upper half of the selected dword.

Each accepted host access produces exactly one response pulse. The host keeps `io_req` low until that response has arrived.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the address register reads as 0x00000000, and no response or downstream request is active.
- R2: Legal accesses are: size code 1 at any byte position; size code 2 at byte positions 0 and 2; size code 4 at byte position 0 only. The position is `io_off[1:0]`, and the same rule applies in both halves of the window. Any other combination, including size codes 0, 3 and 5 to 7, is illegal. An illegal access produces a response with `io_err` high for that one cycle. An illegal read returns 0xFFFFFFFF. An illegal write changes nothing and issues no downstream request.
- R3: A legal write at `io_off` 0 to 3 replaces only the covered bytes of the address register. Write data is taken right-aligned from `io_wdata`. Example: 0x12345678, then 0xFACE written with size 2 at offset 2, gives 0xFACE5678.
- R4: A legal read at `io_off` 0 to 3 returns the covered bytes of the address register right-aligned in `io_rdata`, with all upper bits zero.
- R5: The downstream target fields come from the address register. `cfg_bus` is bits 23:16, `cfg_dev` is bits 15:11 and `cfg_fn` is bits 10:8. Bit 31 is the enable bit.
- R6: A data-window request carries `cfg_reg = {addr[7:2], io_off[1:0]}`. It also carries `cfg_be`, whose set bits mark the covered byte lanes starting at lane `io_off[1:0]`.
- R7: A legal data-window read returns the covered lanes of `cfg_rdata` right-aligned, with the upper bits zero.
- R8: A legal data-window write drives `cfg_we` high. `cfg_wdata` carries the host data shifted into the covered lanes, and every other lane is zero.
- R9: While the enable bit is clear, a data-window access issues no request and raises no error. A read returns 0xFFFFFFFF, and a write changes nothing.
- R10: Every access gets exactly one `io_rsp_valid` pulse, one cycle long, with `io_rsp_size` equal to the requested size code. Writes return zero data. Address-register and locally answered accesses respond in the cycle after acceptance. Forwarded accesses respond in the cycle after the `cfg_req_valid`/`cfg_req_ready` handshake.
- R11: Once `cfg_req_valid` is high, it stays high with unchanged offset, byte enables and write data until `cfg_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | Host access strobe, one cycle |
| io_we | input | 1 | 1 = write, 0 = read |
| io_off | input | 3 | Byte offset in the 8-byte window |
| io_size | input | 3 | Access size in bytes (1, 2 or 4) |
| io_wdata | input | 32 | Right-aligned write data |
| io_rsp_valid | output | 1 | Response pulse |
| io_rdata | output | 32 | Right-aligned read data |
| io_rsp_size | output | 3 | Size code of the answered access |
| io_err | output | 1 | Illegal width or alignment, with the response |
| cfg_req_valid | output | 1 | Downstream request valid |
| cfg_req_ready | input | 1 | Downstream request accepted |
| cfg_we | output | 1 | Downstream write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 8 | Effective register byte offset |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Responder dword for the request's register |

## Verification
Several properties are checked on every cycle. A pending downstream request stays stable until ready (R11). Requests exist only while the enable bit is set (R9). Errors appear only with a response, and a response follows each handshake. Byte enables have a legal shape and size. Unwritten address-register lanes keep their value.

Some behaviour only the bench scenarios can show. These are the exact merged address values, the lane extraction of read data, the effective offset and the shifted write data. The bench sweeps every byte position, size code, direction and a range of responder stall lengths, and computes the expected values arithmetically.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int NBYTES = 4;
  localparam int DW     = 8 * NBYTES;

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  function automatic logic [DW-1:0] size_mask(input logic [2:0] sz);
    case (sz)
      3'd1:    size_mask = 32'h0000_00FF;
      3'd2:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_extract(input logic [DW-1:0] d,
                                                 input logic [1:0] o,
                                                 input logic [2:0] sz);
    lane_extract = (d >> {o, 3'b000}) & size_mask(sz);
  endfunction
endpackage

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
  import cfg_port_pkg::*;
(
  input  logic [1:0]    off,
  input  logic [2:0]    size,
  input  logic [DW-1:0] data,
  output logic          legal,
  output logic [3:0]    be,
  output logic [DW-1:0] data_sh
);
  logic [3:0] base_be;

  always_comb begin
    case (size)
      3'd1: begin legal = 1'b1;          base_be = 4'b0001; end
      3'd2: begin legal = ~off[0];       base_be = 4'b0011; end
      3'd4: begin legal = (off == 2'd0); base_be = 4'b1111; end
      default: begin legal = 1'b0;       base_be = 4'b0000; end
    endcase
    be      = legal ? 4'(base_be << off) : 4'b0000;
    data_sh = (data & size_mask(size)) << {off, 3'b000};
  end
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg #(
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NB-1:0]   be,
  input  logic [8*NB-1:0] wdata,
  output logic [8*NB-1:0] addr_q
);
  logic [8*NB-1:0] addr_d;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign addr_d[8*g +: 8] = be[g] ? wdata[8*g +: 8] : addr_q[8*g +: 8];

    // R3: lanes outside the byte enables keep their value
    p_lane_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !be[g]) |=> $stable(addr_q[8*g +: 8]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= addr_d;
  end

  // R3: no write strobe, no change
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(addr_q));
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_port_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic             io_we,
  input  logic [2:0]       io_off,
  input  logic [2:0]       io_size,
  input  logic [31:0]      io_wdata,
  output logic             io_rsp_valid,
  output logic [31:0]      io_rdata,
  output logic [2:0]       io_rsp_size,
  output logic             io_err,
  output logic             cfg_req_valid,
  input  logic             cfg_req_ready,
  output logic             cfg_we,
  output logic [BUS_W-1:0] cfg_bus,
  output logic [DEV_W-1:0] cfg_dev,
  output logic [FN_W-1:0]  cfg_fn,
  output logic [7:0]       cfg_reg,
  output logic [3:0]       cfg_be,
  output logic [31:0]      cfg_wdata,
  input  logic [31:0]      cfg_rdata
);
  localparam int FN_LSB  = 8;
  localparam int DEV_LSB = FN_LSB + FN_W;
  localparam int BUS_LSB = DEV_LSB + DEV_W;
  localparam int EN_BIT  = DW - 1;

  logic          legal_in;
  logic [3:0]    be_in;
  logic [DW-1:0] wsh_in;
  logic [DW-1:0] addr_q;
  logic          addr_wr;

  st_e           state_q, state_d;
  logic          rsp_valid_q, rsp_valid_d;
  logic          rsp_err_q, rsp_err_d;
  logic [DW-1:0] rsp_data_q, rsp_data_d;
  logic [2:0]    rsp_size_q, rsp_size_d;
  logic          hold_ld;
  logic          h_we_q;
  logic [1:0]    h_off_q;
  logic [2:0]    h_size_q;
  logic [3:0]    h_be_q;
  logic [DW-1:0] h_wdata_q;

  cfg_lane_unit u_lane (
    .off     (io_off[1:0]),
    .size    (io_size),
    .data    (io_wdata),
    .legal   (legal_in),
    .be      (be_in),
    .data_sh (wsh_in)
  );

  assign addr_wr = io_req && (state_q == ST_IDLE) && !io_off[2] && io_we && legal_in;

  cfg_addr_reg #(.NB(NBYTES)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (addr_wr),
    .be     (be_in),
    .wdata  (wsh_in),
    .addr_q (addr_q)
  );

  always_comb begin
    state_d     = state_q;
    rsp_valid_d = 1'b0;
    rsp_err_d   = 1'b0;
    rsp_data_d  = '0;
    rsp_size_d  = rsp_size_q;
    hold_ld     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (io_req) begin
          rsp_size_d = io_size;
          if (!legal_in) begin
            rsp_valid_d = 1'b1;
            rsp_err_d   = 1'b1;
            rsp_data_d  = io_we ? '0 : '1;
          end else if (!io_off[2]) begin
            rsp_valid_d = 1'b1;
            rsp_data_d  = io_we ? '0 : lane_extract(addr_q, io_off[1:0], io_size);
          end else if (!addr_q[EN_BIT]) begin
            rsp_valid_d = 1'b1;
            rsp_data_d  = io_we ? '0 : '1;
          end else begin
            state_d = ST_WAIT;
            hold_ld = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (cfg_req_ready) begin
          state_d     = ST_IDLE;
          rsp_valid_d = 1'b1;
          rsp_data_d  = h_we_q ? '0 : lane_extract(cfg_rdata, h_off_q, h_size_q);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
      rsp_size_q  <= '0;
      h_we_q      <= 1'b0;
      h_off_q     <= '0;
      h_size_q    <= '0;
      h_be_q      <= '0;
      h_wdata_q   <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      rsp_data_q  <= rsp_data_d;
      rsp_size_q  <= rsp_size_d;
      if (hold_ld) begin
        h_we_q    <= io_we;
        h_off_q   <= io_off[1:0];
        h_size_q  <= io_size;
        h_be_q    <= be_in;
        h_wdata_q <= wsh_in;
      end
    end
  end

  assign io_rsp_valid  = rsp_valid_q;
  assign io_rdata      = rsp_data_q;
  assign io_rsp_size   = rsp_size_q;
  assign io_err        = rsp_err_q;
  assign cfg_req_valid = (state_q == ST_WAIT);
  assign cfg_we        = h_we_q;
  assign cfg_be        = h_be_q;
  assign cfg_wdata     = h_wdata_q;
  assign cfg_reg       = {addr_q[7:2], h_off_q};
  assign cfg_bus       = addr_q[BUS_LSB +: BUS_W];
  assign cfg_dev       = addr_q[DEV_LSB +: DEV_W];
  assign cfg_fn        = addr_q[FN_LSB +: FN_W];

  // R2: error only travels with a response
  p_err_with_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    io_err |-> io_rsp_valid);

  // R2: a legal access enables exactly as many lanes as its size
  p_legal_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && state_q == ST_IDLE && legal_in) |-> ($countones(be_in) == int'(io_size)));

  // R9: requests only exist while the enable bit is set
  p_req_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> addr_q[EN_BIT]);

  // R6: request byte enables form a legal lane group
  p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                      4'b0011, 4'b1100, 4'b1111}));

  // R11: a stalled request holds its contents
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_req_ready) |=>
      (cfg_req_valid && $stable(cfg_reg) && $stable(cfg_be) && $stable(cfg_wdata)));

  // R10: each handshake is answered in the next cycle
  p_rsp_after_hs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && cfg_req_ready) |=> io_rsp_valid);
endmodule

// File: tb/tb_cfg_port_decoder.sv
module tb_cfg_port_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_req, io_we;
  logic [2:0]  io_off, io_size;
  logic [31:0] io_wdata;
  logic        io_rsp_valid, io_err;
  logic [31:0] io_rdata;
  logic [2:0]  io_rsp_size;
  logic        cfg_req_valid, cfg_req_ready, cfg_we;
  logic [7:0]  cfg_bus, cfg_reg;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int stall = 0;
  logic [7:0]  wait_cnt;
  logic [31:0] mem     [64];
  logic [31:0] exp_mem [64];

  always #5 clk = ~clk;

  cfg_port_decoder dut (.*);

  assign cfg_rdata     = mem[cfg_reg[7:2]];
  assign cfg_req_ready = cfg_req_valid && (int'(wait_cnt) >= stall);

  always @(posedge clk) begin
    wait_cnt <= (cfg_req_valid && !cfg_req_ready) ? wait_cnt + 8'd1 : 8'd0;
    if (cfg_req_valid && cfg_req_ready && cfg_we)
      for (int b = 0; b < 4; b++)
        if (cfg_be[b]) mem[cfg_reg[7:2]][8*b +: 8] <= cfg_wdata[8*b +: 8];
  end

  // results of the last access
  logic [31:0] r_data;
  logic        r_err, r_got, r_seen, r_we, r_pulse_bad;
  logic [2:0]  r_size;
  logic [7:0]  r_reg, r_bus;
  logic [4:0]  r_dev;
  logic [2:0]  r_fn;
  logic [3:0]  r_be;
  logic [31:0] r_wd;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [2:0] off, input logic [2:0] sz,
                        input logic [31:0] wd);
    @(negedge clk);
    io_req = 1'b1; io_we = we; io_off = off; io_size = sz; io_wdata = wd;
    r_got = 1'b0; r_seen = 1'b0;
    for (int i = 0; i < 64 && !r_got; i++) begin
      @(negedge clk);
      io_req = 1'b0;
      if (cfg_req_valid) begin
        r_seen = 1'b1; r_reg = cfg_reg; r_be = cfg_be; r_wd = cfg_wdata; r_we = cfg_we;
        r_bus = cfg_bus; r_dev = cfg_dev; r_fn = cfg_fn;
      end
      if (io_rsp_valid) begin
        r_got = 1'b1; r_data = io_rdata; r_err = io_err; r_size = io_rsp_size;
      end
    end
    @(negedge clk);
    r_pulse_bad = io_rsp_valid | io_err;
  endtask

  function automatic logic is_legal(input logic [1:0] o, input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2 && !o[0]) || (sz == 3'd4 && o == 2'd0);
  endfunction

  function automatic logic [31:0] lmask(input logic [2:0] sz);
    return (sz == 3'd4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * sz)) - 32'd1);
  endfunction

  function automatic logic [31:0] ext(input logic [31:0] d, input logic [1:0] o,
                                      input logic [2:0] sz);
    return (d >> (8 * o)) & lmask(sz);
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] d, input logic [1:0] o,
                                        input logic [2:0] sz, input logic [31:0] wd);
    logic [31:0] m;
    m = lmask(sz) << (8 * o);
    return (d & ~m) | ((wd << (8 * o)) & m);
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] o, input logic [2:0] sz);
    return 4'(((1 << sz) - 1) << o);
  endfunction

  // R10: common response checks
  task automatic check_rsp(input string req, input logic [2:0] sz, input logic e_err,
                           input logic [31:0] e_data);
    check({req, " R10 got"}, {31'd0, r_got}, 32'd1);
    check({req, " R10 size"}, {29'd0, r_size}, {29'd0, sz});
    check({req, " R10 one-cycle"}, {31'd0, r_pulse_bad}, 32'd0);
    check({req, " R2 err"}, {31'd0, r_err}, {31'd0, e_err});
    check({req, " data"}, r_data, e_data);
  endtask

  logic [31:0] exp_addr;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i]     = (32'h9E37_79B9 * (i + 1)) ^ 32'h5A5A_0F0F;
      exp_mem[i] = mem[i];
    end
    rst_n = 1'b0; io_req = 1'b0; io_we = 1'b0; io_off = '0; io_size = '0; io_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 rsp_valid", {31'd0, io_rsp_valid}, 32'd0);
    check("R1 req_valid", {31'd0, cfg_req_valid}, 32'd0);
    access(1'b0, 3'd0, 3'd4, 32'h0);
    check("R1 addr reset value", r_data, 32'h0);
    exp_addr = 32'h0;

    // R3/R4: worked merge example
    access(1'b1, 3'd0, 3'd4, 32'h1234_5678);
    access(1'b0, 3'd2, 3'd2, 32'h0);
    check("R4 half read", r_data, 32'h0000_1234);
    access(1'b0, 3'd1, 3'd1, 32'h0);
    check("R4 byte read", r_data, 32'h0000_0056);
    access(1'b1, 3'd2, 3'd2, 32'h0000_FACE);
    access(1'b0, 3'd0, 3'd4, 32'h0);
    check("R3 half merge", r_data, 32'hFACE_5678);
    access(1'b1, 3'd1, 3'd1, 32'h0000_0099);
    access(1'b0, 3'd0, 3'd4, 32'h0);
    check("R3 byte merge", r_data, 32'hFACE_9978);
    exp_addr = 32'hFACE_9978;

    // R2/R3/R4: address port sweep over every position, size code, direction
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 8; s++)
        for (int w = 1; w >= 0; w--) begin
          logic [31:0] wd;
          logic lg;
          wd = 32'hC0DE_0000 ^ (32'h0103_0507 * (o * 8 + s + 1));
          lg = is_legal(2'(o), 3'(s));
          access(1'(w), 3'(o), 3'(s), wd);
          check("R2 addr no request", {31'd0, r_seen}, 32'd0);
          if (!lg)
            check_rsp("R2 addr illegal", 3'(s), 1'b1, w ? 32'h0 : 32'hFFFF_FFFF);
          else if (w) begin
            exp_addr = merge(exp_addr, 2'(o), 3'(s), wd);
            check_rsp("R3 addr write", 3'(s), 1'b0, 32'h0);
          end else
            check_rsp("R4 addr read", 3'(s), 1'b0, ext(exp_addr, 2'(o), 3'(s)));
          access(1'b0, 3'd0, 3'd4, 32'h0);
          check("R3 addr contents", r_data, exp_addr);
        end

    // R5..R8, R11: data window sweep with stalls
    for (int wi = 0; wi < 2; wi++)
      for (int st = 0; st < 3; st++) begin
        logic [5:0] widx;
        widx = (wi == 0) ? 6'h10 : 6'h3F;
        stall = st;
        exp_addr = 32'h8000_0000 | (32'h5A << 16) | (32'h13 << 11) | (32'h6 << 8) | {24'd0, widx, 2'b00};
        access(1'b1, 3'd0, 3'd4, exp_addr);
        for (int o = 0; o < 4; o++)
          for (int s = 0; s < 8; s++)
            for (int w = 1; w >= 0; w--) begin
              logic [31:0] wd;
              logic lg;
              wd = 32'h3C96_0000 ^ (32'h0B0D_1113 * (o * 8 + s + st + 1));
              lg = is_legal(2'(o), 3'(s));
              access(1'(w), 3'(4 + o), 3'(s), wd);
              if (!lg) begin
                check("R2 data illegal no request", {31'd0, r_seen}, 32'd0);
                check_rsp("R2 data illegal", 3'(s), 1'b1, w ? 32'h0 : 32'hFFFF_FFFF);
              end else begin
                check("R11 request seen", {31'd0, r_seen}, 32'd1);
                check("R6 reg offset", {24'd0, r_reg}, {24'd0, widx, 2'(o)});
                check("R6 byte enables", {28'd0, r_be}, {28'd0, exp_be(2'(o), 3'(s))});
                check("R5 bus", {24'd0, r_bus}, 32'h5A);
                check("R5 dev", {27'd0, r_dev}, 32'h13);
                check("R5 fn", {29'd0, r_fn}, 32'h6);
                check("R8 we", {31'd0, r_we}, {31'd0, 1'(w)});
                if (w) begin
                  check("R8 wdata lanes", r_wd, (wd & lmask(3'(s))) << (8 * o));
                  exp_mem[widx] = merge(exp_mem[widx], 2'(o), 3'(s), wd);
                  check_rsp("R8 data write", 3'(s), 1'b0, 32'h0);
                end else
                  check_rsp("R7 data read", 3'(s), 1'b0, ext(exp_mem[widx], 2'(o), 3'(s)));
              end
            end
        access(1'b0, 3'd4, 3'd4, 32'h0);
        check("R8 dword contents", r_data, exp_mem[widx]);
      end

    // R9: disabled data window
    stall = 0;
    access(1'b1, 3'd3, 3'd1, 32'h0000_0000);
    exp_addr = exp_addr & 32'h00FF_FFFF;
    access(1'b1, 3'd4, 3'd4, 32'hDEAD_BEEF);
    check("R9 write no request", {31'd0, r_seen}, 32'd0);
    check_rsp("R9 disabled write", 3'd4, 1'b0, 32'h0);
    access(1'b0, 3'd6, 3'd2, 32'h0);
    check("R9 read no request", {31'd0, r_seen}, 32'd0);
    check_rsp("R9 disabled read", 3'd2, 1'b0, 32'hFFFF_FFFF);
    access(1'b1, 3'd3, 3'd1, 32'h0000_0080);
    access(1'b0, 3'd4, 3'd4, 32'h0);
    check("R9 memory untouched", r_data, exp_mem[6'h3F]);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule